// File: doc/BRIEF.md
# Programmable TDM Serial Input Deserializer

This block takes one serial time-division-multiplexed input line and recovers its 8-bit channel bytes. Each byte comes out with its channel index and a one-cycle valid strobe. All timing comes from a single sampling clock running at four times the fastest line rate, plus an 8 kHz frame pulse. One frame is therefore always 8192 sampling clocks long, whatever the line rate.

Three static settings shape the stream:
- a rate code that fixes how many sampling clocks each bit lasts;
- a whole-bit delay that shifts the start of channel 0 later than the frame pulse;
- a sampling-point code that picks the quarter of the bit period at which the line is read.

The settings are plain register inputs and are expected to stay stable while the block is out of reset. Every rising edge of the frame pulse reloads the frame position at once, so an early or late pulse takes effect in the same cycle.

Top module: `tdm_rx_deser`

## Requirements
- R1: After a synchronous reset (`rst_ni` low) `valid_o` is 0. It stays 0 until the first rising edge of `fp_i` has been seen, and no byte is delivered before that edge.
- R2: The rate code selects the channels per frame: 0 gives 32, 1 gives 64, 2 gives 128 and 3 gives 256. In any 8192-clock span that starts at a frame edge, exactly that many bytes are delivered, and `chan_o` never exceeds the last channel (31, 63, 127, 255).
- R3: A bit lasts 32, 16, 8 or 4 sampling clocks for rate codes 0, 1, 2 and 3, and a frame lasts 8192 clocks.
- R4: The clock cycle in which `fp_i` is high after being low is frame position 0.
- R5: With a bit delay of D (0 to 7 on `dly_i`), bit 0 of channel 0 occupies frame positions D·L through D·L+L−1, where L is the bit length.
- R6: Inside a bit of length L, the line is read at clock Q·L/4−1 of the bit. The sampling code maps as 0 → Q=3 (the default, 3/4), 1 → Q=1, 2 → Q=2 and 3 → Q=4.
- R7: At rate code 3 only the half and full points exist. Codes selecting Q=1 or Q=2 read at Q=2, and codes selecting Q=3 or Q=4 read at Q=4.
- R8: Bits are packed MSB first. The cycle after the eighth bit of a channel is read, `valid_o` is high for exactly one cycle, with that byte on `byte_o` and its channel index on `chan_o`.
- R9: Every rising edge of `fp_i` reloads the frame position to 0, including one that arrives early. A pulse held high for several clocks causes only one reload.
- R10: When the bit delay pushes the last channel of a frame past the next frame edge, that channel's byte is still delivered after the edge, tagged with the last channel index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, four times the fastest bit rate |
| rst_ni | input | 1 | Synchronous reset, active low |
| fp_i | input | 1 | Frame pulse, active high; the rising edge marks frame position 0 |
| din_i | input | 1 | Serial TDM input line |
| rate_i | input | 2 | Rate code 0..3 (2.048 / 4.096 / 8.192 / 16.384 Mbps) |
| dly_i | input | 3 | Whole-bit input delay, 0..7 |
| smp_i | input | 2 | Sampling-point code |
| byte_o | output | 8 | Completed channel byte |
| chan_o | output | 8 | Channel index of `byte_o` |
| valid_o | output | 1 | One-cycle strobe for a completed byte |

## Verification
A frame edge and the completion of a delayed stream's last channel can occur in the same clock, as can a frame edge and a sampling instant of the previous frame's tail bits. The bench provokes both by running every rate with non-zero delays and steady frame pulses, and once with an early, wide pulse that forces a mid-frame reload. The line is driven with a fresh random bit on every clock, so a read at the wrong quarter or in the wrong frame position changes the byte. A behavioural model tracks frame position, delay and quarter point with plain integers, and every output is compared against it on every clock.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    typedef enum logic [1:0] {
        RATE_2M  = 2'd0,
        RATE_4M  = 2'd1,
        RATE_8M  = 2'd2,
        RATE_16M = 2'd3
    } rate_e;

    typedef enum logic [1:0] {
        SMP_Q3 = 2'd0,
        SMP_Q1 = 2'd1,
        SMP_Q2 = 2'd2,
        SMP_Q4 = 2'd3
    } smp_e;

    // Quarter index 1..4 at which a bit is read; the top rate has only 2 and 4.
    function automatic logic [2:0] quarter_of(input rate_e rate, input smp_e smp);
        logic [2:0] q;
        case (smp)
            SMP_Q1:  q = 3'd1;
            SMP_Q2:  q = 3'd2;
            SMP_Q4:  q = 3'd4;
            default: q = 3'd3;
        endcase
        if (rate == RATE_16M) begin
            q = (q <= 3'd2) ? 3'd2 : 3'd4;
        end
        return q;
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
    parameter int FRAME_W = 13
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               fp_i,
    output logic [FRAME_W-1:0] tick_o,
    output logic               start_o,
    output logic               synced_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] tick;
        logic               fp_prev;
        logic               synced;
    } timer_t;

    timer_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        start_o      = fp_i & ~st_q.fp_prev;
        st_d.fp_prev = fp_i;
        st_d.tick    = start_o ? '0 : st_q.tick + 1'b1;
        st_d.synced  = st_q.synced | start_o;
    end

    assign tick_o   = st_d.tick;
    assign synced_o = st_d.synced;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R9
    frame_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fp_i) |=> (st_q.tick == '0));

    // R1
    sync_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.synced |=> st_q.synced);
endmodule

// File: rtl/tdm_bit_locator.sv
module tdm_bit_locator
    import tdm_rx_pkg::*;
#(
    parameter int FRAME_W = 13,
    parameter int DLY_W   = 3,
    parameter int BIT_W   = 3,
    parameter int CH_W    = 8,
    parameter int QTR_W   = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [FRAME_W-1:0] tick_i,
    input  logic [1:0]         rate_i,
    input  logic [DLY_W-1:0]   dly_i,
    input  logic [1:0]         smp_i,
    output logic               strobe_o,
    output logic [BIT_W-1:0]   bit_pos_o,
    output logic [CH_W-1:0]    chan_o
);
    localparam int NUM_RATES = 4;
    localparam int SH_W      = $clog2(QTR_W + NUM_RATES);
    localparam int IDX_W     = BIT_W + CH_W;

    logic [SH_W-1:0]    shamt;
    logic [FRAME_W-1:0] dly_ticks, eff, mask, phase, point;
    logic [IDX_W-1:0]   bit_idx;
    logic [2:0]         qv;

    always_comb begin
        shamt     = SH_W'(QTR_W) + SH_W'(2'd3 - rate_i);
        dly_ticks = FRAME_W'(dly_i) << shamt;
        eff       = tick_i - dly_ticks;
        bit_idx   = IDX_W'(eff >> shamt);
        mask      = (FRAME_W'(1) << shamt) - FRAME_W'(1);
        phase     = eff & mask;
        qv        = quarter_of(rate_e'(rate_i), smp_e'(smp_i));
        point     = ((FRAME_W'(qv) << shamt) >> QTR_W) - FRAME_W'(1);
        strobe_o  = (phase == point);
        bit_pos_o = bit_idx[BIT_W-1:0];
        chan_o    = bit_idx[BIT_W +: CH_W];
    end

    // R6
    sample_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_o |=> !strobe_o);
endmodule

// File: rtl/tdm_byte_assembler.sv
module tdm_byte_assembler #(
    parameter int BYTE_W = 8,
    parameter int BIT_W  = 3,
    parameter int CH_W   = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              strobe_i,
    input  logic              din_i,
    input  logic [BIT_W-1:0]  bit_pos_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic              synced_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic [CH_W-1:0]   chan_o,
    output logic              valid_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] data;
        logic [CH_W-1:0]   chan;
        logic              valid;
    } asm_t;

    asm_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (strobe_i) begin
            st_d.sh = {st_q.sh[BYTE_W-2:0], din_i};
            if (bit_pos_i == BIT_W'(BYTE_W - 1) && synced_i) begin
                st_d.valid = 1'b1;
                st_d.data  = st_d.sh;
                st_d.chan  = chan_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign byte_o  = st_q.data;
    assign chan_o  = st_q.chan;
    assign valid_o = st_q.valid;

    // R8
    single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.valid |=> !st_q.valid);
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
    parameter int CH_W   = 8,
    parameter int BYTE_W = 8,
    parameter int DLY_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fp_i,
    input  logic              din_i,
    input  logic [1:0]        rate_i,
    input  logic [DLY_W-1:0]  dly_i,
    input  logic [1:0]        smp_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic [CH_W-1:0]   chan_o,
    output logic              valid_o
);
    localparam int BIT_W   = $clog2(BYTE_W);
    localparam int QTR_W   = 2;
    localparam int FRAME_W = CH_W + BIT_W + QTR_W;

    logic [FRAME_W-1:0] tick;
    logic               start, synced, strobe;
    logic [BIT_W-1:0]   bit_pos;
    logic [CH_W-1:0]    loc_chan;

    tdm_frame_timer #(.FRAME_W(FRAME_W)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .fp_i    (fp_i),
        .tick_o  (tick),
        .start_o (start),
        .synced_o(synced)
    );

    tdm_bit_locator #(
        .FRAME_W(FRAME_W), .DLY_W(DLY_W), .BIT_W(BIT_W),
        .CH_W(CH_W), .QTR_W(QTR_W)
    ) u_locator (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .rate_i   (rate_i),
        .dly_i    (dly_i),
        .smp_i    (smp_i),
        .strobe_o (strobe),
        .bit_pos_o(bit_pos),
        .chan_o   (loc_chan)
    );

    tdm_byte_assembler #(.BYTE_W(BYTE_W), .BIT_W(BIT_W), .CH_W(CH_W)) u_asm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_i (strobe),
        .din_i    (din_i),
        .bit_pos_i(bit_pos),
        .chan_i   (loc_chan),
        .synced_i (synced),
        .byte_o   (byte_o),
        .chan_o   (chan_o),
        .valid_o  (valid_o)
    );

    // R1
    valid_after_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> synced);

    // R2
    chan_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> ({1'b0, chan_o} < ((CH_W+1)'(1) << (CH_W - 3 + int'($past(rate_i))))));

    // R4
    start_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start |-> (tick == '0));
endmodule

// File: tb/tdm_rx_deser_test.sv
module tdm_rx_deser_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fp = 1'b0;
    logic       din = 1'b0;
    logic [1:0] rate = 2'd0;
    logic [2:0] dly = 3'd0;
    logic [1:0] smp = 2'd0;
    logic [7:0] byte_o, chan_o;
    logic       valid_o;

    always #10 clk = ~clk;

    tdm_rx_deser uut (
        .clk_i(clk), .rst_ni(rst_n), .fp_i(fp), .din_i(din),
        .rate_i(rate), .dly_i(dly), .smp_i(smp),
        .byte_o(byte_o), .chan_o(chan_o), .valid_o(valid_o)
    );

    int    vec = 0, bad = 0;
    bit    done = 0;
    string tag = "R1";

    // behavioural reference state
    int m_tick, m_sh, e_byte, e_chan;
    bit m_fpp, m_sync, e_valid;
    bit win_arm = 0;
    int win_left = 0, win_cnt = 0;

    function automatic int quarter(int r, int s);
        int q;
        case (s)
            1: q = 1;
            2: q = 2;
            3: q = 4;
            default: q = 3;   // R6 default 3/4
        endcase
        if (r == 3) q = (q <= 2) ? 2 : 4;   // R7
        return q;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tick = 0; m_fpp = 0; m_sync = 0; m_sh = 0; e_valid = 0;
        end else begin
            bit st;
            int cpb, e, bi, ph, sp;
            st = fp && !m_fpp;
            m_fpp = fp;
            m_tick = st ? 0 : (m_tick + 1) % 8192;     // R4 R9
            if (st) m_sync = 1;
            if (st && win_arm) begin
                win_arm = 0; win_left = 8192; win_cnt = 0;
            end
            cpb = 32 >> rate;                          // R3
            e   = (m_tick - int'(dly) * cpb + 8192) % 8192;   // R5
            bi  = e / cpb;
            ph  = e % cpb;
            sp  = quarter(int'(rate), int'(smp)) * cpb / 4 - 1;
            e_valid = 0;
            if (ph == sp) begin
                m_sh = ((m_sh << 1) | int'(din)) & 255;   // R8 MSB first
                if (bi % 8 == 7 && m_sync) begin
                    e_valid = 1; e_byte = m_sh; e_chan = bi / 8;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            vec++;
            if (valid_o !== e_valid) begin
                bad++;
                $display("FAIL [%s] valid got %0b exp %0b", tag, valid_o, e_valid);
            end else if (e_valid) begin
                vec++;
                if (byte_o !== 8'(e_byte) || chan_o !== 8'(e_chan)) begin
                    bad++;
                    $display("FAIL [%s] byte/chan got %0h/%0d exp %0h/%0d",
                             tag, byte_o, chan_o, e_byte, e_chan);
                end
            end
            if (win_left > 0) begin
                if (valid_o === 1'b1) win_cnt++;
                win_left--;
                if (win_left == 0) begin
                    vec++;   // R2 bytes per frame
                    if (win_cnt != (32 << rate)) begin
                        bad++;
                        $display("FAIL [R2] bytes per frame got %0d exp %0d",
                                 win_cnt, 32 << rate);
                    end
                end
            end
        end
    end

    task automatic run_scn(input int r, input int d, input int s,
                           input int w, input int second, input string t);
        @(negedge clk);
        tag = t; rate = 2'(r); dly = 3'(d); smp = 2'(s);
        rst_n = 0; fp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        win_arm = (second == 8192);
        for (int n = 0; n < 100 + 8192 + 600; n++) begin
            fp  = (n >= 100 && n < 100 + w) ||
                  (n >= 100 + second && n < 100 + second + w);
            din = 1'($urandom);
            @(negedge clk);
        end
    endtask

    initial begin
        run_scn(0, 0, 0, 4,  8192, "R1 R3 R6 default 2M");
        run_scn(1, 5, 1, 8,  8192, "R5 R6 4M delay 5 q1");
        run_scn(2, 2, 2, 4,  8192, "R5 R6 8M delay 2 q2");
        run_scn(3, 7, 0, 4,  8192, "R7 R10 16M delay 7 q3->q4");
        run_scn(3, 1, 1, 2,  8192, "R7 16M delay 1 q1->q2");
        run_scn(1, 0, 3, 8,  8192, "R6 R8 4M q4");
        run_scn(2, 3, 0, 16, 5000, "R9 early wide pulse");
        run_scn(0, 7, 3, 4,  8192, "R10 2M delay 7 q4");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            $display("FAIL [watchdog] run incomplete got timeout exp finish");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end
endmodule